// File: doc/BRIEF.md
# Block-Lock Program Protection Controller

This block makes the write-permission decisions for a serial nonvolatile memory. A command decoder upstream turns the serial stream into one-cycle strobes: set or clear the enable latch, write the status register, program the array. This block compares each strobe with the enable latch, the block-protect setting, the pin-enable bit, the active-low protect pin and the busy flag of the internal program cycle. When chip select is released it gives one grant or deny pulse for the operation.

The protect setting write-protects none, the upper quarter, the upper half or all of the array. The protect pin guards only the status register, and only while the pin-enable bit is 1. A low on the pin while the device is still selected cancels a status write that is waiting. Once the write has been granted and the internal cycle is running, the pin has no further effect. Every program operation, granted or refused, clears the enable latch when it ends.

Top module: `blg_top`

## Requirements
- R1: After reset the enable latch, the protect bits and the pin-enable bit are 0. No grant or deny pulse is active, and `statusReg` equals `{7'b0, cycleBusy}`.
- R2: `statusReg` layout: bit 0 mirrors `cycleBusy`, bit 1 is the enable latch, bits 3:2 are the protect field, bit 7 is pin-enable, and bits 6:4 read 0.
- R3: A `cmdSetLatch` strobe while `csN` is low and `cycleBusy` is 0 sets the latch. A `cmdClrLatch` strobe clears it.
- R4: A program request (array or status) made while the latch is 0 is denied and changes nothing.
- R5: Protect field 00 protects nothing, 01 protects the addresses whose two top bits are 11, 10 protects the addresses whose top bit is 1, and 11 protects every address. An array request to a protected address is denied.
- R6: Each decision appears as a single-cycle pulse on exactly one of `arrayGrant`, `arrayDeny`, `statusGrant` or `statusDeny`. The pulse is registered on the first clock edge that samples `csN` high after the request. A granted status write loads `wrBp` and `wrPinEn` on that same edge. Without a grant the status bits stay unchanged.
- R7: With pin-enable 1 and `ppN` low, a status write is denied, while array requests are decided as usual.
- R8: With pin-enable 0, `ppN` has no effect: a status write made while `ppN` is low is granted.
- R9: With pin-enable 1, if `ppN` is low at any clock edge after the status write strobe and before `csN` rises, the write is denied.
- R10: After a status write has been granted, a low on `ppN` while the internal cycle runs leaves the written bits intact.
- R11: A program request made while `cycleBusy` is 1 is denied.
- R12: The latch is cleared on the `csN` rise that ends a program request, whether granted or denied. A selection that carries no program request leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up / power-down) |
| csN | input | 1 | Chip select, active low |
| ppN | input | 1 | Program-protect pin, active low |
| cycleBusy | input | 1 | Internal program cycle running |
| cmdSetLatch | input | 1 | Set-enable-latch command strobe |
| cmdClrLatch | input | 1 | Clear-enable-latch command strobe |
| cmdWriteStatus | input | 1 | Status-register write command strobe |
| cmdProgArray | input | 1 | Array program command strobe |
| addr | input | ADDR_W | Target byte address of an array request |
| wrBp | input | 2 | Protect field carried by a status write |
| wrPinEn | input | 1 | Pin-enable bit carried by a status write |
| arrayGrant | output | 1 | Array program granted (one cycle) |
| arrayDeny | output | 1 | Array program refused (one cycle) |
| statusGrant | output | 1 | Status write granted (one cycle) |
| statusDeny | output | 1 | Status write refused (one cycle) |
| statusReg | output | 8 | Status register contents |

## Verification
The assertions check on every cycle that at most one decision pulse is active and that the status bits change only on a granted write. They also check that a release clears the latch, and that the pending request is marked refused when the latch is missing, when the cycle is busy, when the address is protected, or when the armed pin drops during selection. Only the bench scenarios can show the whole chain from strobe to pulse. This covers the region map walked over several protect settings and boundary addresses, the pin being ignored while pin-enable is 0, and the written bits surviving a pin drop after the grant.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int BUSY_BIT  = 0;
  localparam int LATCH_BIT = 1;
  localparam int BP_LO     = 2;
  localparam int PINEN_BIT = 7;
  localparam int STATUS_W  = 8;

  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic captureData;
    logic loadStatus;
  } regStrobe_t;

  typedef enum logic [1:0] {
    PEND_NONE   = 2'd0,
    PEND_ARRAY  = 2'd1,
    PEND_STATUS = 2'd2
  } pend_e;
endpackage

// File: rtl/blg_regs.sv
module blg_regs
  import blg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic                cycleBusy,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          wrBp,
  input  logic                wrPinEn,
  output logic                latchQ,
  output logic                pinEnQ,
  output logic                addrProtected,
  output logic [STATUS_W-1:0] statusReg
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] bpQ;
  logic [1:0] stageBp;
  logic       stagePinEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (strb.clrLatch) begin
      latchQ <= 1'b0;
    end else if (strb.setLatch) begin
      latchQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageBp    <= 2'b00;
      stagePinEn <= 1'b0;
    end else if (strb.captureData) begin
      stageBp    <= wrBp;
      stagePinEn <= wrPinEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ    <= 2'b00;
      pinEnQ <= 1'b0;
    end else if (strb.loadStatus) begin
      bpQ    <= stageBp;
      pinEnQ <= stagePinEn;
    end
  end

  always_comb begin
    unique case (bpQ)
      2'b00:   addrProtected = 1'b0;
      2'b01:   addrProtected = &addr[TOP -: 2];
      2'b10:   addrProtected = addr[TOP];
      default: addrProtected = 1'b1;
    endcase
  end

  always_comb begin
    statusReg              = '0;
    statusReg[BUSY_BIT]    = cycleBusy;
    statusReg[LATCH_BIT]   = latchQ;
    statusReg[BP_LO +: 2]  = bpQ;
    statusReg[PINEN_BIT]   = pinEnQ;
  end

  // R12: a release strobe leaves the latch clear
  p_latch_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLatch |=> !latchQ);

  // R6: protect bits move only on a granted write
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStatus |=> $stable({bpQ, pinEnQ}));
endmodule

// File: rtl/blg_ctrl.sv
module blg_ctrl
  import blg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       ppN,
  input  logic       cycleBusy,
  input  logic       cmdSetLatch,
  input  logic       cmdClrLatch,
  input  logic       cmdWriteStatus,
  input  logic       cmdProgArray,
  input  logic       latchQ,
  input  logic       pinEnQ,
  input  logic       addrProtected,
  output regStrobe_t strb,
  output logic       arrayGrant,
  output logic       arrayDeny,
  output logic       statusGrant,
  output logic       statusDeny
);
  logic  csPrev;
  pend_e pendKind;
  logic  pendOk;
  logic  csRise;
  logic  pinLock;
  logic  reqArray;
  logic  reqStatus;

  assign csRise    = !csPrev && csN;
  assign pinLock   = pinEnQ && !ppN;
  assign reqArray  = cmdProgArray && !csN;
  assign reqStatus = cmdWriteStatus && !csN;

  always_comb begin
    strb.setLatch    = cmdSetLatch && !csN && !cycleBusy;
    strb.clrLatch    = cmdClrLatch || (csRise && pendKind != PEND_NONE);
    strb.captureData = reqStatus;
    strb.loadStatus  = csRise && pendKind == PEND_STATUS && pendOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      pendKind <= PEND_NONE;
      pendOk   <= 1'b0;
    end else begin
      csPrev <= csN;
      if (csRise) begin
        pendKind <= PEND_NONE;
        pendOk   <= 1'b0;
      end else if (reqArray) begin
        pendKind <= PEND_ARRAY;
        pendOk   <= latchQ && !cycleBusy && !addrProtected;
      end else if (reqStatus) begin
        pendKind <= PEND_STATUS;
        pendOk   <= latchQ && !cycleBusy && !pinLock;
      end else if (pendKind == PEND_STATUS && !csN && pinLock) begin
        pendOk <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrayGrant  <= 1'b0;
      arrayDeny   <= 1'b0;
      statusGrant <= 1'b0;
      statusDeny  <= 1'b0;
    end else begin
      arrayGrant  <= csRise && pendKind == PEND_ARRAY  && pendOk;
      arrayDeny   <= csRise && pendKind == PEND_ARRAY  && !pendOk;
      statusGrant <= csRise && pendKind == PEND_STATUS && pendOk;
      statusDeny  <= csRise && pendKind == PEND_STATUS && !pendOk;
    end
  end

  // R6: one decision pulse at a time
  p_one_decision_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrayGrant, arrayDeny, statusGrant, statusDeny}));

  // R4: no latch, no permission
  p_latch_needed_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((reqArray || reqStatus) && !csRise && !latchQ) |=> !pendOk);

  // R5: protected address refused
  p_protected_refused_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqArray && !csRise && addrProtected) |=> (pendKind == PEND_ARRAY && !pendOk));

  // R9: armed pin cancels a waiting status write
  p_pin_cancel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendKind == PEND_STATUS && !csN && pinLock) |=> !pendOk);

  // R11: busy cycle refuses requests
  p_busy_refused_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((reqArray || reqStatus) && !csRise && cycleBusy) |=> !pendOk);
endmodule

// File: rtl/blg_top.sv
module blg_top
  import blg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                ppN,
  input  logic                cycleBusy,
  input  logic                cmdSetLatch,
  input  logic                cmdClrLatch,
  input  logic                cmdWriteStatus,
  input  logic                cmdProgArray,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          wrBp,
  input  logic                wrPinEn,
  output logic                arrayGrant,
  output logic                arrayDeny,
  output logic                statusGrant,
  output logic                statusDeny,
  output logic [STATUS_W-1:0] statusReg
);
  regStrobe_t strb;
  logic latchQ;
  logic pinEnQ;
  logic addrProtected;

  blg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .ppN(ppN), .cycleBusy(cycleBusy),
    .cmdSetLatch(cmdSetLatch), .cmdClrLatch(cmdClrLatch),
    .cmdWriteStatus(cmdWriteStatus), .cmdProgArray(cmdProgArray),
    .latchQ(latchQ), .pinEnQ(pinEnQ), .addrProtected(addrProtected),
    .strb(strb), .arrayGrant(arrayGrant), .arrayDeny(arrayDeny),
    .statusGrant(statusGrant), .statusDeny(statusDeny)
  );

  blg_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .cycleBusy(cycleBusy),
    .addr(addr), .wrBp(wrBp), .wrPinEn(wrPinEn),
    .latchQ(latchQ), .pinEnQ(pinEnQ), .addrProtected(addrProtected),
    .statusReg(statusReg)
  );
endmodule

// File: tb/tb_blg_top.sv
`timescale 1ns/1ps
module tb_blg_top;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, ppN = 1'b1, cycleBusy = 1'b0;
  logic cmdSetLatch = 1'b0, cmdClrLatch = 1'b0, cmdWriteStatus = 1'b0, cmdProgArray = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0] wrBp = 2'b00;
  logic wrPinEn = 1'b0;
  logic arrayGrant, arrayDeny, statusGrant, statusDeny;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blg_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .ppN(ppN), .cycleBusy(cycleBusy),
    .cmdSetLatch(cmdSetLatch), .cmdClrLatch(cmdClrLatch),
    .cmdWriteStatus(cmdWriteStatus), .cmdProgArray(cmdProgArray),
    .addr(addr), .wrBp(wrBp), .wrPinEn(wrPinEn),
    .arrayGrant(arrayGrant), .arrayDeny(arrayDeny),
    .statusGrant(statusGrant), .statusDeny(statusDeny), .statusReg(statusReg)
  );

  // protect field, address, expected grant
  typedef struct packed { logic [1:0] bp; logic [ADDR_W-1:0] a; logic grant; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'b00, 10'h3FF, 1'b1},
    '{2'b01, 10'h2FF, 1'b1},
    '{2'b01, 10'h300, 1'b0},
    '{2'b01, 10'h3FF, 1'b0},
    '{2'b10, 10'h1FF, 1'b1},
    '{2'b10, 10'h200, 1'b0},
    '{2'b10, 10'h3FF, 1'b0},
    '{2'b11, 10'h000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latchCmd(input bit setIt);
    @(negedge clk) csN = 1'b0; cmdSetLatch = setIt; cmdClrLatch = !setIt;
    @(negedge clk) cmdSetLatch = 1'b0; cmdClrLatch = 1'b0; csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic progArray(input logic [ADDR_W-1:0] a, output logic g, output logic d);
    @(negedge clk) csN = 1'b0; cmdProgArray = 1'b1; addr = a;
    @(negedge clk) cmdProgArray = 1'b0; csN = 1'b1;
    @(negedge clk) g = arrayGrant; d = arrayDeny;
  endtask

  task automatic writeStatus(input logic pe, input logic [1:0] bp, input bit dropPin,
                             output logic g, output logic d);
    @(negedge clk) csN = 1'b0; cmdWriteStatus = 1'b1; wrPinEn = pe; wrBp = bp;
    @(negedge clk) cmdWriteStatus = 1'b0; if (dropPin) ppN = 1'b0;
    @(negedge clk) csN = 1'b1;
    @(negedge clk) g = statusGrant; d = statusDeny;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic g, d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", statusReg, 8'h00);
    check("R1 pulses", {arrayGrant, arrayDeny, statusGrant, statusDeny}, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after release", statusReg, 8'h00);

    // R4 no latch
    progArray(10'h000, g, d);
    check("R4 array deny", {g, d}, 2'b01);
    writeStatus(1'b0, 2'b11, 1'b0, g, d);
    check("R4 status deny", {g, d}, 2'b01);
    check("R4 status unchanged", statusReg, 8'h00);

    // R3 latch set / clear
    latchCmd(1'b1);
    check("R3 latch set", statusReg, 8'h02);
    latchCmd(1'b0);
    check("R3 latch clear", statusReg, 8'h00);

    // R12 plain selection keeps the latch; program op clears it
    latchCmd(1'b1);
    @(negedge clk) csN = 1'b0;
    @(negedge clk) csN = 1'b1;
    @(negedge clk);
    check("R12 latch kept", statusReg[1], 1'b1);
    progArray(10'h155, g, d);
    check("R6 array grant", {g, d}, 2'b10);
    check("R12 latch cleared after grant", statusReg[1], 1'b0);
    @(negedge clk);
    check("R6 single-cycle pulse", arrayGrant, 1'b0);

    // R5 region table, R6 status load, R2 layout
    foreach (VECS[i]) begin
      latchCmd(1'b1);
      writeStatus(1'b0, VECS[i].bp, 1'b0, g, d);
      check("R6 status grant", {g, d}, 2'b10);
      check("R2 layout", statusReg, {6'b0, VECS[i].bp, 2'b00} >> 0 << 0 == 8'h0 ? 8'h00 : {4'b0, VECS[i].bp, 2'b00});
      latchCmd(1'b1);
      progArray(VECS[i].a, g, d);
      check("R5 region decision", {g, d}, {VECS[i].grant, !VECS[i].grant});
      check("R12 latch cleared", statusReg[1], 1'b0);
    end

    // R7 armed pin blocks status writes only
    latchCmd(1'b1);
    writeStatus(1'b1, 2'b00, 1'b0, g, d);
    check("R7 arm pin-enable", statusReg, 8'h80);
    ppN = 1'b0;
    latchCmd(1'b1);
    writeStatus(1'b1, 2'b01, 1'b0, g, d);
    check("R7 status deny", {g, d}, 2'b01);
    check("R7 status unchanged", statusReg, 8'h80);
    latchCmd(1'b1);
    progArray(10'h3FF, g, d);
    check("R7 array still granted", {g, d}, 2'b10);

    // R9 pin drops during selection
    ppN = 1'b1;
    latchCmd(1'b1);
    writeStatus(1'b1, 2'b10, 1'b1, g, d);
    check("R9 cancel", {g, d}, 2'b01);
    check("R9 status unchanged", statusReg, 8'h80);
    ppN = 1'b1;

    // R10 pin after grant has no effect; R2 busy bit
    latchCmd(1'b1);
    writeStatus(1'b1, 2'b01, 1'b0, g, d);
    check("R10 grant", {g, d}, 2'b10);
    cycleBusy = 1'b1; ppN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 bits kept, R2 busy bit", statusReg, 8'h85);
    cycleBusy = 1'b0; ppN = 1'b1;

    // R11 busy refuses
    latchCmd(1'b1);
    cycleBusy = 1'b1;
    progArray(10'h000, g, d);
    check("R11 busy deny", {g, d}, 2'b01);
    cycleBusy = 1'b0;

    // R8 disarm, then pin low is ignored
    latchCmd(1'b1);
    writeStatus(1'b0, 2'b00, 1'b0, g, d);
    check("R8 disarm", statusReg, 8'h00);
    ppN = 1'b0;
    latchCmd(1'b1);
    writeStatus(1'b0, 2'b10, 1'b1, g, d);
    check("R8 grant with pin low", {g, d}, 2'b10);
    check("R8 status loaded", statusReg, 8'h08);
    ppN = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule